// File: doc/BRIEF.md
# Non-blocking data cache request pipeline

This block is the control pipeline of a non-blocking first-level data cache. Each cycle it admits at most one item, either a load/store lookup from the load-store unit or a line refill returning from the next memory level. The item then moves through three fixed stages: tag check, data access and release. A refill is always admitted before a lookup. A lookup that loses to a refill waits in a one-entry holding register and enters on a later cycle. No request is lost.

The tag compare, the replacement state, the data array and the miss-entry file sit outside this block. The block shows the line under check on `lkp_line` and takes back a hit flag and a way number in the same cycle. It tells the miss file when to allocate an entry and when to release one. It feeds the next level through a valid/ready request port, so back-pressure there never stalls the pipeline. A miss request that cannot go out straight away is parked in a small in-order queue and retried on the following cycles.

Both input streams use valid/ready handshakes. A transfer happens on a rising edge where valid and ready are both high. `rfl_ready` is always high. `lsu_ready` falls while the holding register is occupied, or while the miss queue together with the lookups already in flight would fill it. The outgoing request holds its valid and payload steady until the next level takes it.

Top module: `dcache_req_pipe`

## Requirements
- R1: A refill is always accepted (`rfl_ready` high). When a refill and a lookup are both offered in one cycle, the refill enters the tag-check stage first and the lookup follows one cycle later.
- R2: An item accepted on edge t occupies tag check in cycle t+1, data access in cycle t+2 and release in cycle t+3. The pipeline never stalls.
- R3: In tag check, a lookup that hits raises `ack_lkp_valid` with its line. A lookup that misses raises `mshr_alloc` when `mshr_match` and `mshr_full` are both low. A miss with `mshr_match` high joins the existing entry and does not allocate. A miss with `mshr_full` high does not allocate. A refill does nothing in this stage, and `lkp_valid` stays low.
- R4: In data access, a refill raises `fill_we` with its line on `fill_line`.
- R5: In data access, a lookup that allocated a miss entry produces one next-level request carrying its line and the allocated id. If `nl_req_ready` is low, the request is held with a stable payload and retried on every following cycle. Requests leave in lookup order.
- R6: In release, a refill raises `mshr_free` and `ack_wake_valid`, both carrying the refill's id. A lookup does nothing in this stage.
- R7: Every lookup gets exactly one `ack_rd_valid` in data access, in order, with `ack_rd_hit` set as follows. It is 1 for a tag hit, and 1 for a store miss that allocated or joined an entry. It is 0 for a load miss, and 0 for any miss refused because the miss file is full.
- R8: On a tag-check hit, `rep_touch` pulses with `rep_way` equal to the way on `lkp_way` and `rep_set` equal to the low set-index bits of the line. The set index has log2(size/(line*ways)) bits, which is 6 by default.
- R9: While `cfg_always_hit` is high, every lookup reports a hit, whatever `lkp_tag_hit` says.
- R10: A lookup accepted in the same cycle as a refill is held, and `lsu_ready` is low in the next cycle.
- R11: `hit_cnt` counts lookups that hit in tag check and `miss_cnt` counts those that miss. Each counter is CNT_W bits wide and stops at its all-ones value.
- R12: While the next level refuses requests, `lsu_ready` falls before the miss queue could overflow. Once the next level accepts again, every held request is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lsu_valid | input | 1 | Lookup offered |
| lsu_ready | output | 1 | Lookup can be taken |
| lsu_line | input | LINE_W | Line address of the lookup |
| lsu_store | input | 1 | Lookup is a store |
| rfl_valid | input | 1 | Refill offered |
| rfl_ready | output | 1 | Refill can be taken (always 1) |
| rfl_line | input | LINE_W | Line address of the refill |
| rfl_id | input | ID_W | Miss entry the refill answers |
| cfg_always_hit | input | 1 | Force every lookup to hit |
| lkp_valid | output | 1 | A lookup is in tag check |
| lkp_line | output | LINE_W | Line under tag check |
| lkp_tag_hit | input | 1 | Tag compare result for lkp_line |
| lkp_way | input | WAY_W | Way that matched |
| rep_touch | output | 1 | Mark way most recently used |
| rep_set | output | SET_W | Set to update |
| rep_way | output | WAY_W | Way to update |
| mshr_match | input | 1 | A miss entry already covers lkp_line |
| mshr_full | input | 1 | No free miss entry |
| mshr_alloc | output | 1 | Allocate a miss entry |
| mshr_alloc_id | input | ID_W | Id of the entry being allocated |
| mshr_free | output | 1 | Release a miss entry |
| mshr_free_id | output | ID_W | Entry to release |
| ack_lkp_valid | output | 1 | Early hit acknowledgement |
| ack_lkp_line | output | LINE_W | Line of the early acknowledgement |
| ack_rd_valid | output | 1 | Data-access acknowledgement |
| ack_rd_line | output | LINE_W | Line of that acknowledgement |
| ack_rd_hit | output | 1 | Result reported to the load-store unit |
| ack_wake_valid | output | 1 | Wake the load waiting on a refill |
| ack_wake_id | output | ID_W | Entry whose load wakes |
| fill_we | output | 1 | Write refilled line |
| fill_line | output | LINE_W | Line being written |
| nl_req_valid | output | 1 | Miss request to next level |
| nl_req_ready | input | 1 | Next level takes the request |
| nl_req_line | output | LINE_W | Line requested |
| nl_req_id | output | ID_W | Miss entry of the request |
| hit_cnt | output | CNT_W | Saturating hit count |
| miss_cnt | output | CNT_W | Saturating miss count |

## Verification
Lookups are driven with line patterns chosen so the bench's tag and miss-file models produce each outcome in turn: hit, load miss, store miss, join of an existing entry, refusal on a full miss file, and forced hit. Each outcome leaves a distinct mark on the allocate pulse, the reported result and the presence of a next-level request. A refill driven alone shows the per-stage timing. A refill offered together with a lookup shows the admission order and the hold register. A run of misses against a stalled next level separates correct queuing, back-pressure and in-order delivery from a dropped or reordered request. A long burst of hits drives the hit counter into saturation while the miss count stays exact.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  typedef enum logic [1:0] {
    STG_TAG   = 2'd0,
    STG_DATA  = 2'd1,
    STG_FREE  = 2'd2
  } stage_e;

  localparam int unsigned NUM_STAGES = 3;
  localparam int unsigned NUM_CNTS   = 2;
endpackage

// File: rtl/dcp_arbiter.sv
module dcp_arbiter #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rfl_valid,
  input  logic [PW-1:0] rfl_pay,
  input  logic          lsu_valid,
  input  logic [PW-1:0] lsu_pay,
  input  logic          room,
  output logic          lsu_ready,
  output logic          rfl_ready,
  output logic          out_valid,
  output logic [PW-1:0] out_pay,
  output logic          skid_full
);
  logic [PW-1:0] skid_q;
  logic          lsu_take;

  assign rfl_ready = 1'b1;
  assign lsu_ready = !skid_full && room;
  assign lsu_take  = lsu_valid && lsu_ready;

  always_comb begin
    out_valid = 1'b0;
    out_pay   = lsu_pay;
    if (rfl_valid) begin
      out_valid = 1'b1;
      out_pay   = rfl_pay;
    end else if (skid_full) begin
      out_valid = 1'b1;
      out_pay   = skid_q;
    end else if (lsu_take) begin
      out_valid = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skid_full <= 1'b0;
      skid_q    <= '0;
    end else if (lsu_take && rfl_valid) begin
      skid_full <= 1'b1;
      skid_q    <= lsu_pay;
    end else if (skid_full && !rfl_valid) begin
      skid_full <= 1'b0;
    end
  end
endmodule

// File: rtl/dcp_miss_fifo.sv
module dcp_miss_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;

  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= din;
        wr_ptr      <= nxt(wr_ptr);
      end
      if (pop) rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/dcp_sat_cnt.sv
module dcp_sat_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                q <= '0;
    else if (inc && (~q != '0)) q <= q + 1'b1;
  end
endmodule

// File: rtl/dcache_req_pipe.sv
module dcache_req_pipe #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned CACHE_KB   = 32,
  parameter int unsigned WAYS       = 8,
  parameter int unsigned ID_W       = 3,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned MQ_DEPTH   = 4,
  localparam int unsigned OFS_W     = $clog2(LINE_BYTES),
  localparam int unsigned LINE_W    = ADDR_W - OFS_W,
  localparam int unsigned WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned SETS      = (CACHE_KB * 1024) / (LINE_BYTES * WAYS),
  localparam int unsigned SET_W     = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lsu_valid,
  output logic              lsu_ready,
  input  logic [LINE_W-1:0] lsu_line,
  input  logic              lsu_store,
  input  logic              rfl_valid,
  output logic              rfl_ready,
  input  logic [LINE_W-1:0] rfl_line,
  input  logic [ID_W-1:0]   rfl_id,
  input  logic              cfg_always_hit,
  output logic              lkp_valid,
  output logic [LINE_W-1:0] lkp_line,
  input  logic              lkp_tag_hit,
  input  logic [WAY_W-1:0]  lkp_way,
  output logic              rep_touch,
  output logic [SET_W-1:0]  rep_set,
  output logic [WAY_W-1:0]  rep_way,
  input  logic              mshr_match,
  input  logic              mshr_full,
  output logic              mshr_alloc,
  input  logic [ID_W-1:0]   mshr_alloc_id,
  output logic              mshr_free,
  output logic [ID_W-1:0]   mshr_free_id,
  output logic              ack_lkp_valid,
  output logic [LINE_W-1:0] ack_lkp_line,
  output logic              ack_rd_valid,
  output logic [LINE_W-1:0] ack_rd_line,
  output logic              ack_rd_hit,
  output logic              ack_wake_valid,
  output logic [ID_W-1:0]   ack_wake_id,
  output logic              fill_we,
  output logic [LINE_W-1:0] fill_line,
  output logic              nl_req_valid,
  input  logic              nl_req_ready,
  output logic [LINE_W-1:0] nl_req_line,
  output logic [ID_W-1:0]   nl_req_id,
  output logic [CNT_W-1:0]  hit_cnt,
  output logic [CNT_W-1:0]  miss_cnt
);
  import dcp_pkg::*;

  localparam int unsigned QW  = LINE_W + ID_W;
  localparam int unsigned QCW = $clog2(MQ_DEPTH + 1);
  localparam int unsigned UW  = QCW + 2;

  typedef struct packed {
    logic              rfl;
    logic              st;
    logic [LINE_W-1:0] line;
    logic [ID_W-1:0]   id;
  } tag_t;

  typedef struct packed {
    logic              rfl;
    logic [LINE_W-1:0] line;
    logic [ID_W-1:0]   id;
    logic              hit;
    logic              need;
  } data_t;

  // ---- admission ----
  tag_t  rfl_pay, lsu_pay, adm_pay;
  logic  adm_valid, skid_full, room;

  assign rfl_pay = '{rfl: 1'b1, st: 1'b0, line: rfl_line, id: rfl_id};
  assign lsu_pay = '{rfl: 1'b0, st: lsu_store, line: lsu_line, id: '0};

  dcp_arbiter #(.PW($bits(tag_t))) u_arb (
    .clk(clk), .rst_n(rst_n),
    .rfl_valid(rfl_valid), .rfl_pay(rfl_pay),
    .lsu_valid(lsu_valid), .lsu_pay(lsu_pay),
    .room(room),
    .lsu_ready(lsu_ready), .rfl_ready(rfl_ready),
    .out_valid(adm_valid), .out_pay(adm_pay),
    .skid_full(skid_full)
  );

  // ---- stage registers ----
  logic [NUM_STAGES-1:0] vld;
  tag_t                  s_tag;
  data_t                 s_data, s_data_d;
  logic                  s_free_rfl;
  logic [ID_W-1:0]       s_free_id;

  // ---- tag check stage ----
  logic tag_lkp, hit_eff, miss, join_e;
  assign tag_lkp   = vld[STG_TAG] && !s_tag.rfl;
  assign lkp_valid = tag_lkp;
  assign lkp_line  = s_tag.line;
  assign hit_eff   = cfg_always_hit || lkp_tag_hit;
  assign miss      = tag_lkp && !hit_eff;
  assign join_e    = miss && mshr_match;
  assign mshr_alloc    = miss && !mshr_match && !mshr_full;
  assign ack_lkp_valid = tag_lkp && hit_eff;
  assign ack_lkp_line  = s_tag.line;
  assign rep_touch     = ack_lkp_valid;
  assign rep_way       = lkp_way;
  assign rep_set       = s_tag.line[SET_W-1:0];

  always_comb begin
    s_data_d.rfl  = s_tag.rfl;
    s_data_d.line = s_tag.line;
    s_data_d.id   = mshr_alloc ? mshr_alloc_id : s_tag.id;
    s_data_d.hit  = hit_eff || (s_tag.st && (mshr_alloc || join_e));
    s_data_d.need = mshr_alloc;
  end

  // ---- data access stage ----
  logic            data_lkp, need_now, q_push, q_pop, q_empty;
  logic [QW-1:0]   q_head;
  logic [QCW-1:0]  q_count;

  assign data_lkp     = vld[STG_DATA] && !s_data.rfl;
  assign fill_we      = vld[STG_DATA] && s_data.rfl;
  assign fill_line    = s_data.line;
  assign ack_rd_valid = data_lkp;
  assign ack_rd_line  = s_data.line;
  assign ack_rd_hit   = s_data.hit;
  assign need_now     = data_lkp && s_data.need;

  assign nl_req_valid = !q_empty || need_now;
  assign {nl_req_line, nl_req_id} = q_empty ? {s_data.line, s_data.id} : q_head;
  assign q_pop  = !q_empty && nl_req_ready;
  assign q_push = need_now && !(q_empty && nl_req_ready);

  dcp_miss_fifo #(.W(QW), .DEPTH(MQ_DEPTH)) u_mq (
    .clk(clk), .rst_n(rst_n),
    .push(q_push), .din({s_data.line, s_data.id}),
    .pop(q_pop), .dout(q_head), .empty(q_empty), .count(q_count)
  );

  // Every lookup already admitted may still need a queue slot.
  logic [UW-1:0] used;
  assign used = UW'(q_count) + UW'(tag_lkp) + UW'(need_now) + UW'(skid_full);
  assign room = (used < UW'(MQ_DEPTH));

  // ---- release stage ----
  assign mshr_free      = vld[STG_FREE] && s_free_rfl;
  assign mshr_free_id   = s_free_id;
  assign ack_wake_valid = mshr_free;
  assign ack_wake_id    = s_free_id;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld        <= '0;
      s_tag      <= '0;
      s_data     <= '0;
      s_free_rfl <= 1'b0;
      s_free_id  <= '0;
    end else begin
      vld        <= {vld[STG_DATA], vld[STG_TAG], adm_valid};
      s_tag      <= adm_pay;
      s_data     <= s_data_d;
      s_free_rfl <= s_data.rfl;
      s_free_id  <= s_data.id;
    end
  end

  // ---- statistics ----
  logic [NUM_CNTS-1:0] cnt_inc;
  logic [CNT_W-1:0]    cnt_q [NUM_CNTS];
  assign cnt_inc = {miss, ack_lkp_valid};

  for (genvar g = 0; g < NUM_CNTS; g++) begin : g_cnt
    dcp_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(cnt_inc[g]), .q(cnt_q[g])
    );
  end

  assign hit_cnt  = cnt_q[0];
  assign miss_cnt = cnt_q[1];
endmodule

// File: rtl/dcache_req_pipe_chk.sv
module dcache_req_pipe_chk #(
  parameter int unsigned LINE_W = 26,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lsu_valid,
  input logic              lsu_ready,
  input logic              rfl_valid,
  input logic              rfl_ready,
  input logic              cfg_always_hit,
  input logic              lkp_valid,
  input logic              ack_lkp_valid,
  input logic              rep_touch,
  input logic              fill_we,
  input logic              mshr_free,
  input logic              ack_rd_valid,
  input logic              nl_req_valid,
  input logic              nl_req_ready,
  input logic [LINE_W-1:0] nl_req_line,
  input logic [CNT_W-1:0]  hit_cnt
);
  AST_RFL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    rfl_valid |-> rfl_ready);                                       // R1
  AST_FILL_AT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rfl_valid |-> ##2 fill_we);                                     // R4
  AST_FREE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rfl_valid |-> ##3 mshr_free);                                   // R6
  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (lsu_valid && lsu_ready && rfl_valid) |=> !lsu_ready);          // R10
  AST_FORCED_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_always_hit && lkp_valid) |-> ack_lkp_valid);               // R9
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (nl_req_valid && !nl_req_ready) |=> (nl_req_valid && $stable(nl_req_line))); // R5
  AST_TOUCH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rep_touch |-> ack_lkp_valid);                                   // R8
  AST_FILL_NOT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> !ack_rd_valid);                                     // R7
  AST_HIT_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |=> (hit_cnt >= $past(hit_cnt)));                     // R11
endmodule

bind dcache_req_pipe dcache_req_pipe_chk #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .lsu_valid(lsu_valid), .lsu_ready(lsu_ready),
  .rfl_valid(rfl_valid), .rfl_ready(rfl_ready),
  .cfg_always_hit(cfg_always_hit), .lkp_valid(lkp_valid),
  .ack_lkp_valid(ack_lkp_valid), .rep_touch(rep_touch),
  .fill_we(fill_we), .mshr_free(mshr_free), .ack_rd_valid(ack_rd_valid),
  .nl_req_valid(nl_req_valid), .nl_req_ready(nl_req_ready),
  .nl_req_line(nl_req_line), .hit_cnt(hit_cnt)
);

// File: tb/dcache_req_pipe_tb.sv
module dcache_req_pipe_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_W = 26;
  localparam int ID_W   = 3;
  localparam int WAY_W  = 3;
  localparam int SET_W  = 6;
  localparam int CNT_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic lsu_valid = 0, lsu_store = 0, rfl_valid = 0, cfg_always_hit = 0;
  logic mshr_full = 0, nl_req_ready = 1;
  logic [LINE_W-1:0] lsu_line = '0, rfl_line = '0;
  logic [ID_W-1:0]   rfl_id = '0, alloc_id = 3'd2;
  logic lsu_ready, rfl_ready, lkp_valid, lkp_tag_hit, mshr_match, rep_touch;
  logic mshr_alloc, mshr_free, ack_lkp_valid, ack_rd_valid, ack_rd_hit;
  logic ack_wake_valid, fill_we, nl_req_valid;
  logic [LINE_W-1:0] lkp_line, ack_lkp_line, ack_rd_line, fill_line, nl_req_line;
  logic [WAY_W-1:0]  lkp_way, rep_way;
  logic [SET_W-1:0]  rep_set;
  logic [ID_W-1:0]   mshr_free_id, ack_wake_id, nl_req_id;
  logic [CNT_W-1:0]  hit_cnt, miss_cnt;

  // Bench models: bit 6 of the line = tag hit, bit 7 = existing miss entry.
  assign lkp_tag_hit = lkp_line[6];
  assign mshr_match  = lkp_line[7];
  assign lkp_way     = lkp_line[2:0];

  dcache_req_pipe #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lsu_valid(lsu_valid), .lsu_ready(lsu_ready), .lsu_line(lsu_line), .lsu_store(lsu_store),
    .rfl_valid(rfl_valid), .rfl_ready(rfl_ready), .rfl_line(rfl_line), .rfl_id(rfl_id),
    .cfg_always_hit(cfg_always_hit),
    .lkp_valid(lkp_valid), .lkp_line(lkp_line), .lkp_tag_hit(lkp_tag_hit), .lkp_way(lkp_way),
    .rep_touch(rep_touch), .rep_set(rep_set), .rep_way(rep_way),
    .mshr_match(mshr_match), .mshr_full(mshr_full), .mshr_alloc(mshr_alloc),
    .mshr_alloc_id(alloc_id), .mshr_free(mshr_free), .mshr_free_id(mshr_free_id),
    .ack_lkp_valid(ack_lkp_valid), .ack_lkp_line(ack_lkp_line),
    .ack_rd_valid(ack_rd_valid), .ack_rd_line(ack_rd_line), .ack_rd_hit(ack_rd_hit),
    .ack_wake_valid(ack_wake_valid), .ack_wake_id(ack_wake_id),
    .fill_we(fill_we), .fill_line(fill_line),
    .nl_req_valid(nl_req_valid), .nl_req_ready(nl_req_ready),
    .nl_req_line(nl_req_line), .nl_req_id(nl_req_id),
    .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
  );

  int checks = 0, errors = 0;
  int exp_hits = 0, exp_miss = 0;
  logic [LINE_W:0]        q_rd[$];
  logic [LINE_W+ID_W-1:0] q_nl[$];
  logic [ID_W-1:0]        q_free[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Expected results follow R3, R7, R9 from the bench models.
  task automatic expect_lookup(input logic [LINE_W-1:0] ln, input logic st);
    bit th, alloc, joined;
    th     = cfg_always_hit || ln[6];
    joined = !th && ln[7];
    alloc  = !th && !ln[7] && !mshr_full;
    if (th) exp_hits++; else exp_miss++;
    q_rd.push_back({ln, th || (st && (alloc || joined))});
    if (alloc) q_nl.push_back({ln, alloc_id});
  endtask

  task automatic send_lsu(input logic [LINE_W-1:0] ln, input logic st);
    @(negedge clk);
    lsu_valid = 1; lsu_line = ln; lsu_store = st;
    while (!lsu_ready) @(negedge clk);
    expect_lookup(ln, st);
    @(posedge clk);
    lsu_valid <= 0;
  endtask

  task automatic send_rfl(input logic [LINE_W-1:0] ln, input logic [ID_W-1:0] id);
    @(negedge clk);
    rfl_valid = 1; rfl_line = ln; rfl_id = id;
    q_free.push_back(id);
    @(posedge clk);
    rfl_valid <= 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares produced results against the scoreboard queues.
  always @(negedge clk) if (rst_n) begin
    if (ack_rd_valid) begin
      if (q_rd.size() == 0) chk(0, "R7", "unexpected data ack", ack_rd_line, 0);
      else begin
        logic [LINE_W:0] e;
        e = q_rd.pop_front();
        chk({ack_rd_line, ack_rd_hit} == e, "R7", "data ack line/hit",
            {ack_rd_line, ack_rd_hit}, e);
      end
    end
    if (nl_req_valid && nl_req_ready) begin
      if (q_nl.size() == 0) chk(0, "R5", "unexpected next-level request", nl_req_line, 0);
      else begin
        logic [LINE_W+ID_W-1:0] e;
        e = q_nl.pop_front();
        chk({nl_req_line, nl_req_id} == e, "R5", "next-level request",
            {nl_req_line, nl_req_id}, e);
      end
    end
    if (mshr_free) begin
      if (q_free.size() == 0) chk(0, "R6", "unexpected free", mshr_free_id, 0);
      else begin
        logic [ID_W-1:0] e;
        e = q_free.pop_front();
        chk(mshr_free_id == e && ack_wake_valid && ack_wake_id == e, "R6",
            "free and wake id", {ack_wake_valid, mshr_free_id}, {1'b1, e});
      end
    end
  end

  bit finished = 0;
  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      chk(0, "WDOG", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [LINE_W-1:0] ln;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(lsu_ready && rfl_ready && !nl_req_valid && !lkp_valid, "R1", "reset handshake",
        {lsu_ready, rfl_ready, nl_req_valid, lkp_valid}, 4'b1100);
    chk(hit_cnt == 0 && miss_cnt == 0, "R11", "reset counters", {hit_cnt, miss_cnt}, 0);

    // Hit: early ack plus replacement touch
    ln = 26'h0000_0045 | 26'h40;
    send_lsu(ln, 0);
    @(negedge clk);
    chk(ack_lkp_valid && ack_lkp_line == ln, "R3", "early hit ack", ack_lkp_line, ln);
    chk(rep_touch && rep_way == ln[2:0] && rep_set == ln[5:0], "R8", "replacement touch",
        {rep_touch, rep_set, rep_way}, {1'b1, ln[5:0], ln[2:0]});
    idle(4);

    // Load miss allocates
    ln = 26'h0000_0103;
    send_lsu(ln, 0);
    @(negedge clk);
    chk(mshr_alloc && !ack_lkp_valid, "R3", "load miss allocates", {mshr_alloc, ack_lkp_valid}, 2'b10);
    idle(4);

    // Store miss allocates, reported as hit
    alloc_id = 3'd5;
    send_lsu(26'h0000_0211, 1);
    idle(5);

    // Join: existing entry, no allocation
    ln = 26'h0000_0081;
    send_lsu(ln, 0);
    @(negedge clk);
    chk(!mshr_alloc && lkp_valid, "R3", "join does not allocate", mshr_alloc, 0);
    idle(4);

    // Full miss file: refused
    mshr_full = 1;
    send_lsu(26'h0000_0302, 0);
    @(negedge clk);
    chk(!mshr_alloc, "R3", "full miss file refuses", mshr_alloc, 0);
    idle(4);
    mshr_full = 0;

    // Always-hit mode
    cfg_always_hit = 1;
    send_lsu(26'h0000_0404, 0);
    @(negedge clk);
    chk(ack_lkp_valid, "R9", "forced hit", ack_lkp_valid, 1);
    idle(4);
    cfg_always_hit = 0;

    // Refill alone: stage timing
    send_rfl(26'h0000_0500, 3'd6);
    @(negedge clk);
    chk(!lkp_valid && !ack_lkp_valid, "R3", "refill idle in tag check", lkp_valid, 0);
    @(negedge clk);
    chk(fill_we && fill_line == 26'h500, "R4", "refill writes line in data stage", fill_line, 26'h500);
    @(negedge clk);
    chk(mshr_free, "R2", "refill releases in third stage", mshr_free, 1);
    idle(3);

    // Collision: refill wins, lookup held
    @(negedge clk);
    rfl_valid = 1; rfl_line = 26'h600; rfl_id = 3'd1; q_free.push_back(3'd1);
    lsu_valid = 1; lsu_line = 26'h0000_0641; lsu_store = 0;
    expect_lookup(26'h641, 0);
    @(posedge clk);
    rfl_valid <= 0; lsu_valid <= 0;
    @(negedge clk);
    chk(!lsu_ready, "R10", "hold register blocks new lookups", lsu_ready, 0);
    chk(!lkp_valid, "R1", "refill enters first", lkp_valid, 0);
    @(negedge clk);
    chk(fill_we && lkp_valid && lkp_line == 26'h641, "R1", "lookup follows refill",
        {fill_we, lkp_line}, {1'b1, 26'h641});
    idle(5);

    // Stalled next level: back-pressure, then in-order delivery
    nl_req_ready = 0;
    alloc_id = 3'd4;
    fork
      for (int i = 0; i < 6; i++) send_lsu(26'h1000 + LINE_W'(i * 256), 0);
    join_none
    idle(30);
    chk(!lsu_ready, "R12", "lookups blocked while queue full", lsu_ready, 0);
    chk(nl_req_valid && nl_req_line == 26'h1000, "R5", "oldest request held",
        nl_req_line, 26'h1000);
    nl_req_ready = 1;
    wait fork;
    idle(10);
    chk(q_nl.size() == 0, "R12", "all held requests delivered", q_nl.size(), 0);
    chk(miss_cnt == CNT_W'(exp_miss), "R11", "miss count exact", miss_cnt, exp_miss);

    // Saturation
    for (int i = 0; i < 20; i++) send_lsu(26'h2040 + LINE_W'(i * 256), 0);
    idle(6);
    chk(hit_cnt == CNT_W'((exp_hits > 15) ? 15 : exp_hits), "R11", "hit count saturates",
        hit_cnt, 15);
    chk(q_rd.size() == 0 && q_free.size() == 0, "R7", "every lookup acknowledged",
        q_rd.size() + q_free.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule